// File: doc/BRIEF.md
# Burst-Draining Serial Transmit Port

This block is the transmit and status half of a serial port. A host reaches it through a small register interface. Bytes written to the transmit data register are collected in a 16-entry buffer. They are not sent right away. A pacing tick drives a short countdown, and every new byte restarts that countdown. When the countdown runs out, the whole buffer leaves the block in order as a byte stream with a valid/ready handshake. The buffer is then empty, and two transmit status flags are raised.

Receive data enter only as an "available" flag and a byte value. A data-ready status bit samples the available flag on every tick and again after each read of the receive data register. Two interrupt lines, one for receive and one for transmit, are each formed from an enable bit and status bits. Each line is held in a register that changes only when its condition changes.

The sequencer has three states. `ST_IDLE` holds while the buffer is not being counted down. It moves to `ST_WAIT` when an accepted transmit write arrives. `ST_WAIT` stays in place when another write arrives, which reloads the countdown. It moves to `ST_DRAIN` when the countdown expires on a tick. `ST_DRAIN` presents one byte per handshake and returns to `ST_IDLE` when the last buffered byte is accepted.

Register map (3-bit address, 8-bit write data, 16-bit read data): 0 control, 1 status, 2 transmit data (write), 3 receive data (read), 4 level.

Top module: `txburst_uart`

## Requirements
- R1: Each write to address 2 appends one byte to the buffer, which holds up to 16 bytes. Reading address 4 returns the buffer occupancy in bits 15:8 and the receive-available input in bit 0, with all other bits zero.
- R2: A write to address 2 while the buffer already holds 16 bytes first empties the buffer and then stores the new byte, so the occupancy becomes 1 and only that byte is sent.
- R3: Each accepted transmit write loads a countdown of 2 ticks. The burst starts only on the tick that takes the countdown to zero. A write after the first tick therefore postpones the burst by two more ticks.
- R4: When the last byte of a burst is accepted, the occupancy becomes 0 and status bits 1 (transmit empty) and 2 (transmit end) are set.
- R5: The receive interrupt condition is control bit 0 AND status bit 0 (data ready).
- R6: The transmit interrupt condition is control bit 1 AND (status bit 1 OR status bit 2).
- R7: Each interrupt output is registered. It rises on a 0-to-1 change of its condition and falls on a 1-to-0 change, one clock after the state change that causes it.
- R8: Status bit 0 takes the receive-available input on every tick and on every read of address 3. A read of address 3 returns the receive byte input in bits 7:0.
- R9: A write to address 1 replaces status bits 2:0 with write data bits 2:0, and the interrupts follow the new value.
- R10: During a burst, the output byte is valid each cycle. It advances only when ready is high, and stays stable while ready is low.
- R11: A transmit write that arrives during a burst is discarded. It leaves the occupancy and the sent bytes unchanged.
- R12: After reset the buffer is empty, the countdown is clear, status reads 3'b110, control reads 0, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect at address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| tick | input | 1 | Pacing pulse for countdown and data-ready sampling |
| rx_avail | input | 1 | Receive byte available |
| rx_byte | input | 8 | Receive byte value |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Line side accepts byte |
| tx_byte | output | 8 | Output byte |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The assertions assume three things about the inputs. The host never writes the status register in the same cycle that a burst completes. Strobes are single-cycle pulses. Reset is held for at least one clock. The stimulus meets these assumptions by giving every register access its own cycle, by pulsing tick for exactly one cycle, and by waiting for the output stream to go idle before it touches the status register.

// File: rtl/txburst_pkg.sv
package txburst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DRAIN = 2'd2
    } tx_state_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_TXD  = 3'd2;
    localparam logic [2:0] A_RXD  = 3'd3;
    localparam logic [2:0] A_LVL  = 3'd4;

    localparam int SB_DRDY = 0;
    localparam int SB_TEMP = 1;
    localparam int SB_TEND = 2;
    localparam int CB_RIE  = 0;
    localparam int CB_TIE  = 1;

    localparam int N_IRQ = 2;
endpackage

// File: rtl/txburst_fifo.sv
module txburst_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          flush,
    input  logic [IW-1:0] rd_idx,
    output logic [CW-1:0] count,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] count_q;
    logic          full;
    logic [IW-1:0] wr_idx;

    assign full    = (count_q == CW'(DEPTH));
    assign wr_idx  = full ? '0 : count_q[IW-1:0];
    assign count   = count_q;
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_idx] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (flush) begin
            count_q <= '0;
        end else if (push) begin
            count_q <= full ? CW'(1) : count_q + CW'(1);
        end
    end

    // R1
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // R2
    overrun_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !flush && full |=> count_q == CW'(1));
endmodule

// File: rtl/txburst_delay.sv
module txburst_delay #(
    parameter int TICKS = 2,
    localparam int TW   = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expire,
    output logic busy
);
    logic [TW-1:0] cnt_q;

    assign busy   = (cnt_q != '0);
    assign expire = tick && !load && (cnt_q == TW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= TW'(TICKS);
        end else if (tick && busy) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    // R3
    delay_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == TW'(TICKS));

    // R3
    delay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TW'(TICKS));
endmodule

// File: rtl/txburst_irq.sv
module txburst_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic irq
);
    logic irq_q;

    assign irq = irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (cond != irq_q) begin
            irq_q <= cond;
        end
    end
endmodule

// File: rtl/txburst_uart.sv
module txburst_uart
    import txburst_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int DELAY_TICKS = 2,
    localparam int CW         = $clog2(DEPTH + 1),
    localparam int IW         = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        tick,
    input  logic        rx_avail,
    input  logic [7:0]  rx_byte,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_byte,
    output logic        irq_rx,
    output logic        irq_tx
);
    tx_state_e     state_q, state_d;
    logic [1:0]    ctrl_q;
    logic [2:0]    stat_q;
    logic [IW-1:0] rd_idx_q;
    logic [CW-1:0] level;
    logic [7:0]    head_byte;
    logic          txd_wr, stat_wr, ctrl_wr, rxd_rd;
    logic          push, expire, cd_busy;
    logic          last_byte, handshake, drain_done;
    logic [N_IRQ-1:0] irq_cond, irq_vec;

    assign txd_wr  = reg_wr && (reg_addr == A_TXD);
    assign stat_wr = reg_wr && (reg_addr == A_STAT);
    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign rxd_rd  = reg_rd && (reg_addr == A_RXD);
    assign push    = txd_wr && (state_q != ST_DRAIN);

    txburst_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(reg_wdata),
        .flush(drain_done), .rd_idx(rd_idx_q), .count(level), .rd_data(head_byte)
    );

    txburst_delay #(.TICKS(DELAY_TICKS)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(push), .tick(tick),
        .expire(expire), .busy(cd_busy)
    );

    assign handshake  = (state_q == ST_DRAIN) && tx_ready;
    assign last_byte  = (CW'(rd_idx_q) + CW'(1)) >= level;
    assign drain_done = handshake && last_byte;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (push) state_d = ST_WAIT;
            ST_WAIT:  if (expire) state_d = ST_DRAIN;
            ST_DRAIN: if (drain_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        tx_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  tx_valid = 1'b0;
            ST_WAIT:  tx_valid = 1'b0;
            ST_DRAIN: tx_valid = 1'b1;
            default:  tx_valid = 1'b0;
        endcase
    end
    assign tx_byte = head_byte;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx_q <= '0;
        end else if (drain_done) begin
            rd_idx_q <= '0;
        end else if (handshake) begin
            rd_idx_q <= rd_idx_q + IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= reg_wdata[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 3'b110;
        end else if (stat_wr) begin
            stat_q <= reg_wdata[2:0];
        end else begin
            if (tick || rxd_rd) stat_q[SB_DRDY] <= rx_avail;
            if (drain_done) begin
                stat_q[SB_TEMP] <= 1'b1;
                stat_q[SB_TEND] <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata = {14'd0, ctrl_q};
            A_STAT:  reg_rdata = {13'd0, stat_q};
            A_RXD:   reg_rdata = {8'd0, rx_byte};
            A_LVL:   reg_rdata = {8'(level), 7'd0, rx_avail};
            default: reg_rdata = '0;
        endcase
    end

    assign irq_cond[0] = ctrl_q[CB_RIE] && stat_q[SB_DRDY];
    assign irq_cond[1] = ctrl_q[CB_TIE] && (stat_q[SB_TEMP] || stat_q[SB_TEND]);

    for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
        txburst_irq u_irq (.clk(clk), .rst_n(rst_n), .cond(irq_cond[g]), .irq(irq_vec[g]));
    end
    assign irq_rx = irq_vec[0];
    assign irq_tx = irq_vec[1];

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

    // R4
    burst_done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done && !stat_wr |=> stat_q[SB_TEMP] && stat_q[SB_TEND] && level == '0);

    // R11
    drain_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && txd_wr && !drain_done |=> $stable(level));

    // R5
    rx_irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx) |-> $past(ctrl_q[CB_RIE]));

    // R6
    tx_irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_tx) |-> $past(ctrl_q[CB_TIE]));

    // R3
    burst_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(state_q == ST_WAIT) && $past(tick));
endmodule

// File: tb/sim_txburst_uart.sv
module sim_txburst_uart;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tick = 1'b0, rx_avail = 1'b0, tx_ready = 1'b1;
    logic [7:0]  rx_byte = '0;
    logic        tx_valid, irq_rx, irq_tx;
    logic [7:0]  tx_byte;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q [$];

    always #4 clk = ~clk;

    txburst_uart u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tick(tick), .rx_avail(rx_avail), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // driver: model the buffer in the scoreboard queue
    task automatic send(input logic [7:0] b, input bit during_burst);
        if (!during_burst) begin
            if (exp_q.size() == 16) exp_q.delete();
            exp_q.push_back(b);
        end
        wr(3'd2, b);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 200 && tx_valid; g++) @(negedge clk);
    endtask

    // monitor: compare every accepted byte
    always begin
        @(negedge clk);
        #3;
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected byte", tx_byte, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(tx_byte == e, "R3 burst order", tx_byte, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  held;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R12 reset state
        rd(3'd1, d); chk(d == 16'h0006, "R12 status", d, 16'h0006);
        rd(3'd0, d); chk(d == 16'h0000, "R12 control", d, 0);
        rd(3'd4, d); chk(d == 16'h0000, "R12 level", d, 0);
        chk(!irq_rx && !irq_tx, "R12 irqs low", {irq_rx, irq_tx}, 0);

        // R1 fill and level
        wr(3'd1, 8'h00);
        send(8'hA1, 0); send(8'hB2, 0); send(8'hC3, 0);
        rd(3'd4, d); chk(d[15:8] == 8'd3, "R1 occupancy", d[15:8], 3);

        // R3 two ticks then burst
        pulse_tick();
        chk(!tx_valid, "R3 no burst after one tick", tx_valid, 0);
        pulse_tick();
        chk(tx_valid, "R3 burst after second tick", tx_valid, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R3 all bytes sent", exp_q.size(), 0);
        rd(3'd4, d); chk(d[15:8] == 8'd0, "R4 occupancy cleared", d[15:8], 0);
        rd(3'd1, d); chk(d[2:1] == 2'b11, "R4 empty and end flags", d[2:1], 3);

        // R3 reload postpones burst
        send(8'h11, 0);
        pulse_tick();
        send(8'h22, 0);
        pulse_tick();
        chk(!tx_valid, "R3 reload postpones", tx_valid, 0);
        pulse_tick();
        chk(tx_valid, "R3 burst after reload", tx_valid, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R3 reload bytes sent", exp_q.size(), 0);

        // R2 overrun
        for (int i = 0; i < 16; i++) send(8'(8'h40 + i), 0);
        rd(3'd4, d); chk(d[15:8] == 8'd16, "R1 full", d[15:8], 16);
        send(8'h99, 0);
        rd(3'd4, d); chk(d[15:8] == 8'd1, "R2 overrun restart", d[15:8], 1);
        pulse_tick(); pulse_tick();
        wait_idle();
        chk(exp_q.size() == 0, "R2 only new byte sent", exp_q.size(), 0);

        // R10 stall, R11 write during burst
        tx_ready = 1'b0;
        send(8'h5C, 0); send(8'h6D, 0);
        pulse_tick(); pulse_tick();
        held = tx_byte;
        cyc(3);
        chk(tx_valid && tx_byte == held, "R10 stall holds byte", tx_byte, held);
        send(8'h77, 1);
        rd(3'd4, d); chk(d[15:8] == 8'd2, "R11 write discarded", d[15:8], 2);
        tx_ready = 1'b1;
        wait_idle();
        chk(exp_q.size() == 0 && !tx_valid, "R11 no extra byte", exp_q.size(), 0);

        // R6/R7 transmit interrupt
        wr(3'd0, 8'h02);
        chk(!irq_tx, "R7 one-cycle latency", irq_tx, 0);
        cyc(1);
        chk(irq_tx, "R6 tx irq asserts", irq_tx, 1);
        wr(3'd1, 8'h00);
        cyc(1);
        chk(!irq_tx, "R9 status clear drops tx irq", irq_tx, 0);
        rd(3'd1, d); chk(d == 16'h0000, "R9 status replaced", d, 0);
        wr(3'd1, 8'h04);
        cyc(1);
        chk(irq_tx, "R6 end flag alone", irq_tx, 1);

        // R5/R8 receive interrupt
        wr(3'd0, 8'h01);
        cyc(1);
        chk(!irq_tx, "R7 tx irq falls", irq_tx, 0);
        rx_avail = 1'b1; rx_byte = 8'h5A;
        chk(!irq_rx, "R8 no sample before tick", irq_rx, 0);
        pulse_tick();
        cyc(1);
        chk(irq_rx, "R5 rx irq asserts", irq_rx, 1);
        rd(3'd4, d); chk(d[0] == 1'b1, "R1 available bit", d[0], 1);
        rx_avail = 1'b0;
        rd(3'd3, d); chk(d[7:0] == 8'h5A, "R8 receive byte", d[7:0], 8'h5A);
        rd(3'd1, d); chk(d[0] == 1'b0, "R8 ready resampled", d[0], 0);
        chk(!irq_rx, "R5 rx irq deasserts", irq_rx, 0);

        finish_run();
    end
endmodule